// File: doc/BRIEF.md
# Lockable GPIO Register Bank

This block holds the configuration and event registers of a 32-pin general-purpose I/O controller. A plain word bus reaches it through an address, a write strobe, a read strobe, write data and read data. The register values leave the block as parallel buses that drive the pin resolver and the event detector beside it. The pin resolver returns the sampled input word, which software can read. The event detector returns a per-pin mask of events, which is folded into a sticky status word.

A two-key lock protects the bank. Once it is engaged, only the two lock words accept writes, and every other write is dropped and flagged. Set and clear alias addresses let software change single bits of the data-out, output-enable and event-enable words without a read-modify-write. Slots for blink, debounce and similar features only store what is written to them. The per-pin lock slots ignore writes.

Reads return data one cycle after the read strobe. Illegal accesses raise a one-cycle error pulse, kept separately for reads and for writes.

Top module: `gpio_lockbank`

## Requirements
- R1: After reset every register reads 0, except pull-up (0x1C), pull-down (0x20), slew (0x5C) and drive (0x60). Those four load the parameters RST_PU, RST_PD, RST_SLEW and RST_DRIVE. The bank starts unlocked, and the lock word at 0x00 reads 0.
- R2: The plain read/write words are: polarity 0x08, data-out 0x0C, output-enable 0x10, output-type 0x14, pull-up 0x1C, pull-down 0x20, event-type 0x28, both-edge 0x2C, event-enable 0x40, input-mask 0x58, slew 0x5C and drive 0x60. A write updates the word and its output bus on the next edge. `rd_data` shows the word in the cycle after `rd_en`, and is 0 when no read was issued.
- R3: While unlocked, a write of any value to 0x00 or 0x7C locks the bank. The word at 0x00 then reads 1, and the stored key at 0x7C is cleared.
- R4: While locked, a write to 0x7C stores the key. A write to 0x00 unlocks the bank, clearing both lock words, only if the stored key is 0xC0DE1248 and the written value is 0xC0DEFA73. Any other write to 0x00 leaves the bank locked and raises no error.
- R5: While locked, a write to any offset other than 0x00 and 0x7C changes nothing. It pulses `wr_err` in the following cycle.
- R6: Alias writes change bits in their target word. 0x68 ORs into data-out and 0x6C clears from data-out. 0x70 ORs into output-enable and 0x74 clears from output-enable. 0x44 ORs into event-enable and 0x48 clears from event-enable. In each case the written data is the mask of bits to change.
- R7: The event status word at 0x4C sets a bit for each bit of `ev_hit` that is high. Writing a 1 to a bit of 0x4C clears that bit, and a written 0 leaves the bit as it was. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: A read of a write-only address returns 0 and pulses `rd_err` in the next cycle. The write-only addresses are 0x44, 0x48 and 0x68 to 0x7C. A read of an unmapped address does the same: 0x64, or anything at 0x80 and above. A write to 0x64, 0x78 or any address at 0x80 and above changes nothing and pulses `wr_err`.
- R9: An access with address bits [1:0] nonzero is ignored. It returns 0 and pulses the matching error flag in the next cycle.
- R10: A read of 0x04 returns `din` as sampled on the read edge. A write to 0x04 changes nothing and pulses `wr_err`.
- R11: The words at 0x18, 0x24 and 0x30 to 0x3C store and read back what is written, and drive no output. Writes to 0x50 and 0x54 are ignored without an error, and those two addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_err | output | 1 | Illegal read pulse |
| wr_err | output | 1 | Illegal or locked write pulse |
| din | input | 32 | Sampled input word from the pin resolver |
| ev_hit | input | 32 | Per-pin event pulses from the event detector |
| pol | output | 32 | Polarity word |
| dout | output | 32 | Data-out word |
| oe | output | 32 | Output-enable word |
| otype | output | 32 | Output-type word |
| pu | output | 32 | Pull-up word |
| pd | output | 32 | Pull-down word |
| inmask | output | 32 | Input-mask word |
| evtype | output | 32 | Event-type word |
| evboth | output | 32 | Both-edge word |
| evenable | output | 32 | Event-enable word |
| evstatus | output | 32 | Event status word |
| slew | output | 32 | Slew-rate word |
| drive | output | 32 | Drive-strength word |

## Verification
The bench builds the block with ADDR_W = 12 and with four different non-zero patterns for the reset parameters. This lets it tell each reset-loaded word apart from the others and from zero. The 12-bit address reaches both the offsets above 0x7C and the misaligned offsets. The lock sequences tried are a missing key, a wrong unlock value and the correct key pair, with each of the two lock words used to engage the lock.

// File: rtl/gpio_lockbank.sv
module gpio_lockbank #(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] RST_PU    = 32'h0,
  parameter logic [31:0] RST_PD    = 32'h0,
  parameter logic [31:0] RST_SLEW  = 32'h0,
  parameter logic [31:0] RST_DRIVE = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rd_err,
  output logic              wr_err,
  input  logic [31:0]       din,
  input  logic [31:0]       ev_hit,
  output logic [31:0]       pol,
  output logic [31:0]       dout,
  output logic [31:0]       oe,
  output logic [31:0]       otype,
  output logic [31:0]       pu,
  output logic [31:0]       pd,
  output logic [31:0]       inmask,
  output logic [31:0]       evtype,
  output logic [31:0]       evboth,
  output logic [31:0]       evenable,
  output logic [31:0]       evstatus,
  output logic [31:0]       slew,
  output logic [31:0]       drive
);
  localparam logic [31:0] KEY_PRE  = 32'hC0DE_1248;
  localparam logic [31:0] KEY_OPEN = 32'hC0DE_FA73;
  localparam int          NSPARE   = 6;

  logic        lock_q;
  logic [31:0] key_q;
  logic [31:0] spare_q [NSPARE];
  logic [31:0] rmux;

  wire [4:0] idx     = addr[6:2];
  wire       aligned = addr[1:0] == 2'b00;
  wire       inrange = (addr >> 7) == '0;
  wire       wr_ok   = wr_en & aligned & inrange;
  wire       rd_ok   = rd_en & aligned & inrange;
  wire       wr_open = wr_ok & ~lock_q;

  wire rd_wonly = (idx == 5'd17) | (idx == 5'd18) | (idx == 5'd25) | (idx >= 5'd26);
  wire wr_hole  = (idx == 5'd1) | (idx == 5'd25) | (idx == 5'd30);
  wire rd_bad   = rd_en & ~(rd_ok & ~rd_wonly);
  wire wr_bad   = wr_en & ~(wr_ok & (lock_q ? (idx == 5'd0 || idx == 5'd31) : ~wr_hole));
  wire [31:0] st_clr = (wr_open && idx == 5'd19) ? wr_data : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0; key_q <= '0;
      pol <= '0; dout <= '0; oe <= '0; otype <= '0;
      pu <= RST_PU; pd <= RST_PD; slew <= RST_SLEW; drive <= RST_DRIVE;
      inmask <= '0; evtype <= '0; evboth <= '0; evenable <= '0;
      for (int k = 0; k < NSPARE; k++) spare_q[k] <= '0;
    end else if (wr_ok) begin
      if (lock_q) begin
        if (idx == 5'd31)
          key_q <= wr_data;
        else if (idx == 5'd0 && key_q == KEY_PRE && wr_data == KEY_OPEN) begin
          lock_q <= 1'b0;
          key_q  <= '0;
        end
      end else begin
        case (idx)
          5'd0, 5'd31: begin lock_q <= 1'b1; key_q <= '0; end
          5'd2:  pol      <= wr_data;
          5'd3:  dout     <= wr_data;
          5'd4:  oe       <= wr_data;
          5'd5:  otype    <= wr_data;
          5'd6:  spare_q[0] <= wr_data;
          5'd7:  pu       <= wr_data;
          5'd8:  pd       <= wr_data;
          5'd9:  spare_q[1] <= wr_data;
          5'd10: evtype   <= wr_data;
          5'd11: evboth   <= wr_data;
          5'd12, 5'd13, 5'd14, 5'd15: spare_q[2 + int'(idx[1:0])] <= wr_data;
          5'd16: evenable <= wr_data;
          5'd17: evenable <= evenable | wr_data;
          5'd18: evenable <= evenable & ~wr_data;
          5'd22: inmask   <= wr_data;
          5'd23: slew     <= wr_data;
          5'd24: drive    <= wr_data;
          5'd26: dout     <= dout | wr_data;
          5'd27: dout     <= dout & ~wr_data;
          5'd28: oe       <= oe | wr_data;
          5'd29: oe       <= oe & ~wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evstatus <= '0;
    else        evstatus <= (evstatus & ~st_clr) | ev_hit;

  always_comb begin
    case (idx)
      5'd0:  rmux = {31'b0, lock_q};
      5'd1:  rmux = din;
      5'd2:  rmux = pol;
      5'd3:  rmux = dout;
      5'd4:  rmux = oe;
      5'd5:  rmux = otype;
      5'd6:  rmux = spare_q[0];
      5'd7:  rmux = pu;
      5'd8:  rmux = pd;
      5'd9:  rmux = spare_q[1];
      5'd10: rmux = evtype;
      5'd11: rmux = evboth;
      5'd12, 5'd13, 5'd14, 5'd15: rmux = spare_q[2 + int'(idx[1:0])];
      5'd16: rmux = evenable;
      5'd19: rmux = evstatus;
      5'd22: rmux = inmask;
      5'd23: rmux = slew;
      5'd24: rmux = drive;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; rd_err <= 1'b0; wr_err <= 1'b0;
    end else begin
      rd_data <= (rd_en && !rd_bad) ? rmux : 32'h0;
      rd_err  <= rd_bad;
      wr_err  <= wr_bad;
    end
  end

  a_r3_lock_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !lock_q && (idx == 5'd0 || idx == 5'd31)) |=> (lock_q && key_q == 32'h0));

  a_r4_key_required: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(wr_ok && idx == 5'd0 && key_q == KEY_PRE && wr_data == KEY_OPEN)) |=> lock_q);

  a_r5_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && wr_en && !(idx == 5'd0 || idx == 5'd31)) |=>
      ($stable(dout) && $stable(oe) && $stable(pol) && $stable(evenable) && wr_err));

  a_r8_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == 32'h0);

  a_r9_misaligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[1:0] != 2'b00) |=> wr_err);

  a_r7_hit_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit != 32'h0) |=> ((evstatus & $past(ev_hit)) == $past(ev_hit)));
endmodule

// File: tb/sim_gpio_lockbank.sv
module sim_gpio_lockbank;
  localparam logic [31:0] P_PU = 32'h0000_F00F, P_PD = 32'h0F00_0000;
  localparam logic [31:0] P_SL = 32'h3300_0000, P_DR = 32'h0000_0CC0;
  localparam logic [31:0] K1 = 32'hC0DE_FA73, K2 = 32'hC0DE_1248;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, din = '0, ev_hit = '0;
  logic [31:0] rd_data, pol, dout, oe, otype, pu, pd, inmask, evtype, evboth, evenable, evstatus, slew, drive;
  logic rd_err, wr_err;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_lockbank #(.ADDR_W(12), .RST_PU(P_PU), .RST_PD(P_PD), .RST_SLEW(P_SL), .RST_DRIVE(P_DR)) u0 (
    .clk, .rst_n, .addr, .wr_en, .rd_en, .wr_data, .rd_data, .rd_err, .wr_err, .din, .ev_hit,
    .pol, .dout, .oe, .otype, .pu, .pd, .inmask, .evtype, .evboth, .evenable, .evstatus, .slew, .drive);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m [32];
  logic [31:0] m_rd;
  logic m_re, m_we;
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      m[7] = P_PU; m[8] = P_PD; m[23] = P_SL; m[24] = P_DR;
      m_rd = 0; m_re = 0; m_we = 0;
    end else begin
      int i;
      bit al, rg;
      i = int'(addr[6:2]);
      al = addr[1:0] == 0;
      rg = addr < 12'h80;
      m_rd = 0; m_re = 0; m_we = 0;
      if (rd_en) begin
        if (!al || !rg || i == 17 || i == 18 || i == 25 || i >= 26) m_re = 1;
        else if (i == 1) m_rd = din;
        else if (i == 20 || i == 21) m_rd = 0;
        else m_rd = m[i];
      end
      if (wr_en) begin
        if (!al || !rg) m_we = 1;
        else if (m[0] == 1) begin
          if (i == 31) m[31] = wr_data;
          else if (i == 0) begin
            if (m[31] == K2 && wr_data == K1) begin m[0] = 0; m[31] = 0; end
          end else m_we = 1;
        end else begin
          case (i)
            0, 31: begin m[0] = 1; m[31] = 0; end
            1, 25, 30: m_we = 1;
            20, 21: ;
            17: m[16] |= wr_data;
            18: m[16] &= ~wr_data;
            19: m[19] &= ~wr_data;
            26: m[3] |= wr_data;
            27: m[3] &= ~wr_data;
            28: m[4] |= wr_data;
            29: m[4] &= ~wr_data;
            default: m[i] = wr_data;
          endcase
        end
      end
      m[19] |= ev_hit;
    end
  end

  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      chk(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
      chk(rd_err == m_re, "R8 rd_err", rd_err, m_re);
      chk(wr_err == m_we, "R5 wr_err", wr_err, m_we);
      chk(dout == m[3] && oe == m[4] && evenable == m[16], "R6 alias targets", dout ^ oe ^ evenable, m[3] ^ m[4] ^ m[16]);
      chk(evstatus == m[19], "R7 evstatus", evstatus, m[19]);
      chk(pol == m[2] && otype == m[5] && pu == m[7] && pd == m[8] && evtype == m[10] && evboth == m[11]
          && inmask == m[22] && slew == m[23] && drive == m[24], "R2 outputs", pol, m[2]);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit e, input string tag);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    chk(wr_err == e, tag, 32'(wr_err), 32'(e));
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] x, input bit e, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(rd_data == x, tag, rd_data, x);
    chk(rd_err == e, tag, 32'(rd_err), 32'(e));
  endtask

  initial begin
    #40000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 0 && pu == P_PU && pd == P_PD && slew == P_SL && drive == P_DR, "R1 reset outputs", pu, P_PU);
    rst_n = 1;
    rd(12'h000, 0, 0, "R1 lock word");
    rd(12'h01C, P_PU, 0, "R1 pull-up");
    rd(12'h020, P_PD, 0, "R1 pull-down");
    rd(12'h05C, P_SL, 0, "R1 slew");
    rd(12'h060, P_DR, 0, "R1 drive");
    rd(12'h00C, 0, 0, "R1 dout");
    wr(12'h008, 32'hA5A5_0F0F, 0, "R2 pol wr");
    rd(12'h008, 32'hA5A5_0F0F, 0, "R2 pol rd");
    wr(12'h058, 32'hFFFF_0000, 0, "R2 inmask wr");
    rd(12'h058, 32'hFFFF_0000, 0, "R2 inmask rd");
    wr(12'h02C, 32'h0000_8001, 0, "R2 evboth wr");
    wr(12'h00C, 32'h0000_00F0, 0, "R2 dout wr");
    wr(12'h068, 32'h0000_000F, 0, "R6 dout set");
    rd(12'h00C, 32'h0000_00FF, 0, "R6 dout after set");
    wr(12'h06C, 32'h0000_0030, 0, "R6 dout clear");
    rd(12'h00C, 32'h0000_00CF, 0, "R6 dout after clear");
    wr(12'h070, 32'h0000_0011, 0, "R6 oe set");
    wr(12'h074, 32'h0000_0001, 0, "R6 oe clear");
    rd(12'h010, 32'h0000_0010, 0, "R6 oe");
    wr(12'h044, 32'h0000_000C, 0, "R6 even set");
    wr(12'h048, 32'h0000_0004, 0, "R6 even clear");
    rd(12'h040, 32'h0000_0008, 0, "R6 even");
    @(negedge clk); ev_hit = 32'h0000_0305; @(negedge clk); ev_hit = 0;
    rd(12'h04C, 32'h0000_0305, 0, "R7 sticky");
    wr(12'h04C, 32'h0000_0101, 0, "R7 w1c");
    rd(12'h04C, 32'h0000_0204, 0, "R7 after w1c");
    wr(12'h04C, 32'h0, 0, "R7 write zero");
    rd(12'h04C, 32'h0000_0204, 0, "R7 zero no effect");
    @(negedge clk); ev_hit = 32'h4; wr_en = 1; addr = 12'h04C; wr_data = 32'h4;
    @(negedge clk); ev_hit = 0; wr_en = 0;
    rd(12'h04C, 32'h0000_0204, 0, "R7 set wins");
    rd(12'h044, 0, 1, "R8 read even-set alias");
    rd(12'h068, 0, 1, "R8 read dout-set alias");
    rd(12'h07C, 0, 1, "R8 read key word");
    rd(12'h064, 0, 1, "R8 read hole");
    rd(12'h080, 0, 1, "R8 read above range");
    wr(12'h064, 32'h1, 1, "R8 write hole");
    wr(12'h084, 32'h1, 1, "R8 write above range");
    wr(12'h00A, 32'h0, 1, "R9 misaligned write");
    rd(12'h008, 32'hA5A5_0F0F, 0, "R9 pol kept");
    rd(12'h009, 0, 1, "R9 misaligned read");
    din = 32'h1234_5678;
    rd(12'h004, 32'h1234_5678, 0, "R10 din read");
    wr(12'h004, 32'hFFFF_FFFF, 1, "R10 din write");
    rd(12'h004, 32'h1234_5678, 0, "R10 din unchanged");
    wr(12'h030, 32'h0000_DEAD, 0, "R11 spare wr");
    rd(12'h030, 32'h0000_DEAD, 0, "R11 spare rd");
    wr(12'h024, 32'h0000_BEEF, 0, "R11 spare2 wr");
    rd(12'h024, 32'h0000_BEEF, 0, "R11 spare2 rd");
    wr(12'h050, 32'hFFFF_FFFF, 0, "R11 per-pin lock wr");
    rd(12'h050, 0, 0, "R11 per-pin lock rd");
    wr(12'h07C, 32'h1, 0, "R3 lock via key word");
    rd(12'h000, 32'h1, 0, "R3 locked");
    wr(12'h00C, 32'h0, 1, "R5 locked dout write");
    wr(12'h068, 32'hFFFF_FFFF, 1, "R5 locked alias write");
    rd(12'h00C, 32'h0000_00CF, 0, "R5 dout kept");
    wr(12'h000, K1, 0, "R4 unlock without key");
    rd(12'h000, 32'h1, 0, "R4 still locked");
    wr(12'h07C, K2, 0, "R4 key store");
    wr(12'h000, 32'h0000_1234, 0, "R4 wrong open value");
    rd(12'h000, 32'h1, 0, "R4 still locked 2");
    wr(12'h000, K1, 0, "R4 correct open");
    rd(12'h000, 32'h0, 0, "R4 unlocked");
    wr(12'h00C, 32'h0, 0, "R4 write after unlock");
    rd(12'h00C, 32'h0, 0, "R4 dout cleared");
    wr(12'h000, 32'hFFFF, 0, "R3 lock via word 0");
    rd(12'h000, 32'h1, 0, "R3 locked again");
    wr(12'h07C, 32'h0, 0, "R4 wrong key");
    wr(12'h000, K1, 0, "R4 open with wrong key");
    rd(12'h000, 32'h1, 0, "R4 remains locked");
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule